// File: doc/BRIEF.md
# Two-Master Atomic Read-Modify-Write Memory Arbiter

This block shares one single-port memory between two bus masters. Each master has an address strobe, a write select, a data strobe and a ready handshake. The arbiter gives the memory to one master at a time and steers address and data. The master keeps the memory for as long as it holds its address strobe. A master that keeps the strobe high across a read and a later write therefore gets an indivisible read-modify-write sequence. The other master waits with no ready until the strobe drops.

The memory behind the arbiter loses a word when that word is read. After a plain read the arbiter writes the captured word back to the same address before anyone else reaches the memory. If the owning master writes inside its locked window, that write takes the place of the restore. Memory reads take one clock.

The controller is a state machine with five states:
- `ST_IDLE`: no owner.
- `ST_OWNED`: a master holds the grant and a transfer may start.
- `ST_READ`: read data is returning.
- `ST_HOLD`: a transfer is done and the arbiter waits for the data strobe or the address strobe to drop.
- `ST_RESTORE`: the write-back cycle.

Its transitions:
- IDLE→OWNED on any request.
- OWNED→READ when a read is issued.
- OWNED→HOLD when a write is issued.
- OWNED→RESTORE when a read arrives with a restore still pending, or when the strobe drops with a restore pending.
- OWNED→IDLE when the strobe drops with nothing pending.
- READ→HOLD always.
- HOLD→OWNED when the data strobe drops.
- HOLD→RESTORE or HOLD→IDLE when the address strobe drops.
- RESTORE→OWNED when the strobe is still high, otherwise RESTORE→IDLE.

Top module: `lockarb_rmw`

## Requirements
- R1: During and right after reset, no grant is given, both ready bits are low and the memory enable is low.
- R2: At most one master is granted. A granted master keeps the grant on every cycle after a cycle in which its address strobe is high, including while its data strobe is low between phases.
- R3: While one master owns the memory, the other master's ready stays low and its address never reaches the memory.
- R4: When both address strobes are high in the same idle cycle, the grant goes to the master that did not own the memory last. After reset, master 0 (bit 0 of each paired bus) wins the first tie.
- R5: A read is issued in the cycle its data strobe is seen while granted. Data and ready come in the next cycle. From an idle bus, a read is ready two cycles after the strobes rise.
- R6: A plain read causes exactly one restore write of the captured word to its address. This happens before the grant moves, even when the strobe has already dropped, so a later read returns the same value.
- R7: In a locked read-then-write window, the master's own write replaces the restore. Exactly one memory write occurs, and the word becomes the written value.
- R8: A write is issued and acknowledged with ready in the same cycle its data strobe is seen while granted. From an idle bus, this is one cycle after the strobes rise.
- R9: A second read inside one strobe window is preceded by the restore of the first read, so both reads return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_as | input | 2 | Address strobe per master (bit k = master k) |
| req_we | input | 2 | Write select per master, 1 = write |
| req_ds | input | 2 | Data strobe per master |
| req_addr | input | 2*AW | Address per master, master k in slice k |
| req_wdata | input | 2*DW | Write data per master, master k in slice k |
| rsp_rdata | output | DW | Read data, valid with the owner's ready |
| rsp_rdy | output | 2 | Ready per master |
| gnt | output | 2 | One-hot grant, zero when idle |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after a read |

## Verification
The bench runs plain reads, plain writes, locked increments and double reads from a single master. Each of these shows a different outcome: whether a restore was issued, whether it was skipped, or whether it was issued between two reads. It also runs pairs of locked increments from both masters on the same word, started in the same cycle. Those pairs reveal any lost update that a broken lock would cause. Directed cases add a long data-strobe gap while the other master waits, ties taken both ways, and exact ready latencies, and a memory model in the bench compares every word read back.

// File: rtl/lockarb_pkg.sv
package lockarb_pkg;
    localparam int NM = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OWNED,
        ST_READ,
        ST_HOLD,
        ST_RESTORE
    } arb_state_t;
endpackage

// File: rtl/lockarb_pick.sv
module lockarb_pick
    import lockarb_pkg::*;
(
    input  logic [NM-1:0] req,
    input  logic          last,
    output logic          pick
);
    // Both requesting: the one that did not own last wins.
    always_comb begin
        if (req == {NM{1'b1}}) pick = ~last;
        else                   pick = req[1];
    end
endmodule

// File: rtl/lockarb_fsm.sv
module lockarb_fsm
    import lockarb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NM-1:0] req_as,
    input  logic [NM-1:0] req_ds,
    input  logic [NM-1:0] req_we,
    output logic [NM-1:0] gnt,
    output logic [NM-1:0] rsp_rdy,
    output logic          mem_en,
    output logic          mem_we,
    output logic          sel_saved,
    output logic          capture,
    output logic          owner
);
    arb_state_t state, nstate;
    logic own, pend, pick;
    logic as_o, ds_o, we_o;

    assign as_o  = req_as[own];
    assign ds_o  = req_ds[own];
    assign we_o  = req_we[own];
    assign owner = own;

    lockarb_pick pick_i (.req(req_as), .last(own), .pick(pick));

    // next state
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:    if (|req_as) nstate = ST_OWNED;
            ST_OWNED: begin
                if (!as_o)                 nstate = pend ? ST_RESTORE : ST_IDLE;
                else if (ds_o && we_o)     nstate = ST_HOLD;
                else if (ds_o)             nstate = pend ? ST_RESTORE : ST_READ;
            end
            ST_READ:    nstate = ST_HOLD;
            ST_HOLD: begin
                if (!as_o)       nstate = pend ? ST_RESTORE : ST_IDLE;
                else if (!ds_o)  nstate = ST_OWNED;
            end
            ST_RESTORE: nstate = as_o ? ST_OWNED : ST_IDLE;
            default:    nstate = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            own   <= 1'b1;
            pend  <= 1'b0;
        end else begin
            state <= nstate;
            if (state == ST_IDLE && |req_as) own <= pick;
            if (state == ST_OWNED && as_o && ds_o && we_o) pend <= 1'b0;
            else if (state == ST_READ)                     pend <= 1'b1;
            else if (state == ST_RESTORE)                  pend <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        gnt       = '0;
        rsp_rdy   = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        sel_saved = 1'b0;
        capture   = 1'b0;
        if (state != ST_IDLE) gnt[own] = 1'b1;
        unique case (state)
            ST_OWNED: if (as_o && ds_o) begin
                if (we_o) begin
                    mem_en       = 1'b1;
                    mem_we       = 1'b1;
                    rsp_rdy[own] = 1'b1;
                end else if (!pend) begin
                    mem_en = 1'b1;
                end
            end
            ST_READ: begin
                rsp_rdy[own] = 1'b1;
                capture      = 1'b1;
            end
            ST_RESTORE: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                sel_saved = 1'b1;
            end
            default: ;
        endcase
    end

    p_one_owner_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    for (genvar k = 0; k < NM; k++) begin : g_chk
        p_hold_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[k] && req_as[k]) |=> gnt[k]);
        p_foreign_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_rdy[k] |-> gnt[k]);
    end

    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWNED && as_o && ds_o && !we_o && !pend) |=> (rsp_rdy == $past(gnt)));

    p_restore_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !pend);

    p_locked_no_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !pend) |=> (state != ST_RESTORE));
endmodule

// File: rtl/lockarb_path.sv
module lockarb_path
    import lockarb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            owner,
    input  logic            sel_saved,
    input  logic            capture,
    input  logic [NM*AW-1:0] req_addr,
    input  logic [NM*DW-1:0] req_wdata,
    input  logic [DW-1:0]   mem_rdata,
    output logic [AW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic [DW-1:0]   rsp_rdata
);
    logic [AW-1:0] a_s [NM];
    logic [DW-1:0] d_s [NM];
    logic [AW-1:0] sv_addr;
    logic [DW-1:0] sv_data;

    for (genvar k = 0; k < NM; k++) begin : g_slice
        assign a_s[k] = req_addr[k*AW +: AW];
        assign d_s[k] = req_wdata[k*DW +: DW];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sv_addr <= '0;
            sv_data <= '0;
        end else if (capture) begin
            sv_addr <= a_s[owner];
            sv_data <= mem_rdata;
        end
    end

    assign mem_addr  = sel_saved ? sv_addr : a_s[owner];
    assign mem_wdata = sel_saved ? sv_data : d_s[owner];
    assign rsp_rdata = mem_rdata;
endmodule

// File: rtl/lockarb_rmw.sv
module lockarb_rmw
    import lockarb_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM-1:0]    req_as,
    input  logic [NM-1:0]    req_we,
    input  logic [NM-1:0]    req_ds,
    input  logic [NM*AW-1:0] req_addr,
    input  logic [NM*DW-1:0] req_wdata,
    output logic [DW-1:0]    rsp_rdata,
    output logic [NM-1:0]    rsp_rdy,
    output logic [NM-1:0]    gnt,
    output logic             mem_en,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata
);
    logic owner, sel_saved, capture;

    lockarb_fsm fsm_i (
        .clk(clk), .rst_n(rst_n),
        .req_as(req_as), .req_ds(req_ds), .req_we(req_we),
        .gnt(gnt), .rsp_rdy(rsp_rdy),
        .mem_en(mem_en), .mem_we(mem_we),
        .sel_saved(sel_saved), .capture(capture), .owner(owner)
    );

    lockarb_path #(.AW(AW), .DW(DW)) path_i (
        .clk(clk), .rst_n(rst_n),
        .owner(owner), .sel_saved(sel_saved), .capture(capture),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .rsp_rdata(rsp_rdata)
    );
endmodule

// File: tb/lockarb_rmw_tb_top.sv
module lockarb_rmw_tb_top;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int WORDS = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic          b_as [2];
    logic          b_we [2];
    logic          b_ds [2];
    logic [AW-1:0] b_addr [2];
    logic [DW-1:0] b_wd [2];

    logic [1:0]      rsp_rdy, gnt;
    logic [DW-1:0]   rsp_rdata, mem_wdata;
    logic [DW-1:0]   mem_rdata = '0;
    logic [AW-1:0]   mem_addr;
    logic            mem_en, mem_we;

    lockarb_rmw #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_as({b_as[1], b_as[0]}), .req_we({b_we[1], b_we[0]}),
        .req_ds({b_ds[1], b_ds[0]}),
        .req_addr({b_addr[1], b_addr[0]}), .req_wdata({b_wd[1], b_wd[0]}),
        .rsp_rdata(rsp_rdata), .rsp_rdy(rsp_rdy), .gnt(gnt),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // destructive-read memory
    logic [DW-1:0] mem [WORDS];
    logic [DW-1:0] model [WORDS];
    int wcnt = 0;
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr] <= mem_wdata;
                wcnt = wcnt + 1;
            end else begin
                mem_rdata     <= mem[mem_addr];
                mem[mem_addr] <= '0;
            end
        end
    end

    int total = 0;
    int bad = 0;
    bit done = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // first-grant monitor for tie cases
    bit fg_arm = 0;
    int fg = -1;
    always @(negedge clk) if (fg_arm && gnt != 2'b00) begin
        fg = gnt[1] ? 1 : 0;
        fg_arm = 0;
    end

    // blocking monitor
    bit mon3 = 0;
    int v3 = 0;
    always @(negedge clk) if (mon3 && gnt[0]) begin
        if (rsp_rdy[1]) v3++;
        if (mem_en && mem_addr == 4'd9) v3++;
    end

    task automatic phase(input int m, input bit wr, input logic [DW-1:0] wd,
                         output logic [DW-1:0] rd, output int lat);
        b_we[m] = wr; b_wd[m] = wd; b_ds[m] = 1'b1; lat = 0; rd = '0;
        forever begin
            #1;
            if (rsp_rdy[m]) begin rd = rsp_rdata; break; end
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        b_ds[m] = 1'b0; b_we[m] = 1'b0;
    endtask

    // kind: 0 read, 1 write, 2 locked increment, 3 double read
    task automatic op(input int m, input int kind, input logic [AW-1:0] a,
                      input logic [DW-1:0] v, input int gap,
                      output logic [DW-1:0] r1, output logic [DW-1:0] r2, output int lat);
        int l2;
        r2 = '0;
        @(negedge clk);
        b_as[m] = 1'b1; b_addr[m] = a;
        phase(m, kind == 1, v, r1, lat);
        if (kind >= 2) begin
            repeat (gap) @(negedge clk);
            phase(m, kind == 2, r1 + v, r2, l2);
        end
        b_as[m] = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r1, r2, q1, q2;
        int lat, lq, w0;
        void'($urandom(32'd2024));
        for (int i = 0; i < 2; i++) begin
            b_as[i] = 0; b_we[i] = 0; b_ds[i] = 0; b_addr[i] = '0; b_wd[i] = '0;
        end
        for (int i = 0; i < WORDS; i++) begin
            mem[i] = DW'(i * 16'h0101 + 1);
            model[i] = DW'(i * 16'h0101 + 1);
        end
        repeat (3) @(negedge clk);
        chk("R1 gnt", 32'(gnt), 0);
        chk("R1 rdy", 32'(rsp_rdy), 0);
        chk("R1 mem_en", 32'(mem_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 gnt after reset", 32'(gnt), 0);

        // R5 / R8 latency from idle
        op(0, 0, 4'd3, '0, 1, r1, r2, lat);
        chk("R5 read latency", 32'(lat), 2);
        chk("R5 read data", 32'(r1), 32'(model[3]));
        op(1, 1, 4'd4, 16'hBEEF, 1, r1, r2, lat);
        model[4] = 16'hBEEF;
        chk("R8 write latency", 32'(lat), 1);

        // R4 ties: after the writes above master 1 owned last
        repeat (3) @(negedge clk);
        fg_arm = 1;
        fork
            op(0, 0, 4'd1, '0, 1, r1, r2, lat);
            op(1, 0, 4'd2, '0, 1, q1, q2, lq);
        join
        chk("R4 tie to non-last owner (0)", 32'(fg), 0);
        chk("R4 tie loser data", 32'(q1), 32'(model[2]));
        op(1, 0, 4'd6, '0, 1, r1, r2, lat);
        repeat (3) @(negedge clk);
        fg_arm = 1;
        fork
            op(0, 0, 4'd1, '0, 1, r1, r2, lat);
            op(1, 0, 4'd2, '0, 1, q1, q2, lq);
        join
        chk("R4 tie to non-last owner (0 after 1)", 32'(fg), 0);
        op(0, 0, 4'd7, '0, 1, r1, r2, lat);
        repeat (3) @(negedge clk);
        fg_arm = 1;
        fork
            op(0, 0, 4'd1, '0, 1, r1, r2, lat);
            op(1, 0, 4'd2, '0, 1, q1, q2, lq);
        join
        chk("R4 tie to non-last owner (1)", 32'(fg), 1);

        // R6 plain read restores once
        w0 = wcnt;
        op(0, 0, 4'd5, '0, 1, r1, r2, lat);
        chk("R6 restore write count", 32'(wcnt - w0), 1);
        op(1, 0, 4'd5, '0, 1, q1, q2, lq);
        chk("R6 value kept after read", 32'(q1), 32'(model[5]));

        // R7 locked increment, one write only
        w0 = wcnt;
        op(0, 2, 4'd8, 16'd7, 2, r1, r2, lat);
        chk("R7 write count", 32'(wcnt - w0), 1);
        model[8] = model[8] + 16'd7;
        op(0, 0, 4'd8, '0, 1, q1, q2, lq);
        chk("R7 updated word", 32'(q1), 32'(model[8]));

        // R9 double read in one window
        op(1, 3, 4'd10, '0, 1, r1, r2, lat);
        chk("R9 first read", 32'(r1), 32'(model[10]));
        chk("R9 second read", 32'(r2), 32'(model[10]));

        // R2 / R3 long gap while the other master waits
        mon3 = 1; v3 = 0;
        fork
            op(0, 2, 4'd2, 16'd5, 6, r1, r2, lat);
            begin repeat (2) @(negedge clk); op(1, 0, 4'd9, '0, 1, q1, q2, lq); end
        join
        mon3 = 0;
        model[2] = model[2] + 16'd5;
        chk("R3 other master held off", 32'(v3), 0);
        chk("R2 locked read value", 32'(r1), 32'(model[2] - 16'd5));
        chk("R3 waiter data", 32'(q1), 32'(model[9]));

        // random traffic with same-word increment races
        for (int i = 0; i < 150; i++) begin
            int m, kind, gap;
            logic [AW-1:0] a;
            logic [DW-1:0] v, v2;
            m = int'($urandom % 2); kind = int'($urandom % 4);
            a = AW'($urandom); v = DW'($urandom); v2 = DW'($urandom);
            gap = 1 + int'($urandom % 3);
            if ($urandom % 5 == 0) begin
                fork
                    op(0, 2, a, v, gap, r1, r2, lat);
                    op(1, 2, a, v2, 1, q1, q2, lq);
                join
                model[a] = model[a] + v + v2;
                op(m, 0, a, '0, 1, r1, r2, lat);
                chk("R2 race of locked increments", 32'(r1), 32'(model[a]));
            end else begin
                op(m, kind, a, v, gap, r1, r2, lat);
                case (kind)
                    0: chk("R6 random read", 32'(r1), 32'(model[a]));
                    1: model[a] = v;
                    2: begin
                        chk("R7 random locked read", 32'(r1), 32'(model[a]));
                        model[a] = model[a] + v;
                    end
                    default: begin
                        chk("R9 random double read", 32'(r2), 32'(model[a]));
                    end
                endcase
            end
        end

        for (int i = 0; i < WORDS; i++) begin
            op(i % 2, 0, AW'(i), '0, 1, r1, r2, lat);
            chk("R6 final contents", 32'(r1), 32'(model[i]));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule